// File: doc/BRIEF.md
# Receive Frame Match-Table Classifier

This block decides whether each incoming Ethernet frame is kept or discarded. Frame data arrives as a stream of 32-bit words with start and end markers under a valid/ready handshake. A table of match entries is loaded through a plain write port. Each entry tests one frame word, chosen by a word offset, against a 32-bit pattern under a per-bit enable mask. A hit carries an accept flag or a reject flag.

All entries are compared in parallel as the words stream past. When the frame ends, the lowest-numbered entry that hit and carries an action decides the frame. Entry `DEPTH-1` is fixed as a catch-all that accepts, so a frame that no rule catches is kept. A key that straddles a word boundary is split over two entries at consecutive word offsets. A link flag on the first entry ties them into one rule.

Back-pressure rule: `in_ready` is high at all times except during the single verdict cycle that follows the end word of a frame. A word moves only in a cycle where `in_valid` and `in_ready` are both high, and idle cycles inside a frame are allowed. The verdict has no handshake: it is a one-cycle strobe.

Top module: `rx_match_parser`

## Requirements
- R1: A cycle with `cfg_we` high stores the key, mask, word offset, accept, reject, in-use and link fields into entry `cfg_idx`. A stored entry replaces the previous one for every frame that starts afterwards.
- R2: An entry hits when the frame word at index `woff` matches the key on every bit where the mask is 1. Word 0 is the word carrying `in_sof`, and only transferred words are counted, so byte offset equals four times `woff`.
- R3: Entries are scanned from index 0 upward, and the first rule that hits with a flag set gives the verdict. When the reject flag is set, the verdict is drop (`vd_drop`=1) even if accept is also set. When only accept is set, the verdict is keep (`vd_drop`=0). A hitting rule with neither flag set is passed over.
- R4: An entry whose in-use bit is 0 never takes part in a decision.
- R5: An in-use entry with its link flag set forms one rule with the next entry. That rule hits only if both entries hit and the next entry is in use, and it takes its action from the first entry. The linked second entry never acts as a rule on its own.
- R6: Entry `DEPTH-1` is fixed from reset as in use, with a zero mask and the accept flag set, and writes to it are ignored. A frame that no rule catches is therefore kept.
- R7: A write whose `cfg_woff` exceeds `MAX_OFF_BYTES/4` is ignored and leaves the entry unchanged. An offset equal to that limit is usable.
- R8: A frame that ends before word `woff` does not hit that entry, and no hit state carries over from an earlier frame.
- R9: `vd_valid` is high for exactly one cycle: the cycle after the end word is transferred. `vd_drop` holds the verdict during that cycle.
- R10: `in_ready` is low during the verdict cycle and high otherwise, and idle cycles between words of a frame do not change the result.
- R11: During and after reset `vd_valid` is 0, `in_ready` is 1, and every writable entry is out of use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(DEPTH) | Entry index to write |
| cfg_key | input | 32 | Match pattern |
| cfg_mask | input | 32 | Per-bit compare enable |
| cfg_woff | input | 8 | Word offset into the frame |
| cfg_acc | input | 1 | Accept flag |
| cfg_rej | input | 1 | Reject flag |
| cfg_used | input | 1 | Entry in use |
| cfg_link | input | 1 | Entry chains with the next entry |
| in_valid | input | 1 | Frame word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Frame word |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| vd_valid | output | 1 | Verdict strobe |
| vd_drop | output | 1 | 1 = drop, 0 = keep |

## Verification
The bench loads rules that compete for the same frames. An earlier accept must beat a later reject, and an earlier reject must beat a later accept. A design that picked the wrong priority would flip those verdicts.

A split key is tested three ways: with both halves present, with only the first half, and with only the second half. The second entry is loaded with a reject flag, so a design that treated it as a standalone rule would drop a frame that must be kept. The last position the offset limit allows is hit with a frame just long enough, then missed with a frame one word shorter, which catches word counts that are off by one or carry over from the previous frame.

Writes with an offset past the limit, and writes to the catch-all entry, are followed by frames whose verdict would flip if the write had landed. An unused entry and an entry with no action are placed ahead of a deciding entry, and a design that honoured either would return the wrong verdict.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
  localparam int WOFF_W = 8;  // covers word offsets up to 256 bytes / 4

  typedef struct packed {
    logic [31:0]       key;
    logic [31:0]       mask;
    logic [WOFF_W-1:0] woff;
    logic              acc;
    logic              rej;
    logic              used;
    logic              link;
  } rmp_entry_t;
endpackage

// File: rtl/rmp_table.sv
module rmp_table
  import rmp_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_WOFF = 16,
  localparam int IDXW    = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDXW-1:0]                idx,
  input  rmp_entry_t                     wr,
  output logic [DEPTH-1:0][31:0]         key_v,
  output logic [DEPTH-1:0][31:0]         mask_v,
  output logic [DEPTH-1:0][WOFF_W-1:0]   woff_v,
  output logic [DEPTH-1:0]               acc_v,
  output logic [DEPTH-1:0]               rej_v,
  output logic [DEPTH-1:0]               used_v,
  output logic [DEPTH-1:0]               link_v
);
  logic wr_ok;
  assign wr_ok = we && (wr.woff <= WOFF_W'(MAX_WOFF));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_rw
      rmp_entry_t r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          r <= '0;
        else if (wr_ok && idx == IDXW'(i))   r <= wr;
      end
      assign key_v[i]  = r.key;
      assign mask_v[i] = r.mask;
      assign woff_v[i] = r.woff;
      assign acc_v[i]  = r.acc;
      assign rej_v[i]  = r.rej;
      assign used_v[i] = r.used;
      assign link_v[i] = r.link;
    end else begin : g_pass
      // catch-all: always in use, zero mask, accept
      assign key_v[i]  = '0;
      assign mask_v[i] = '0;
      assign woff_v[i] = '0;
      assign acc_v[i]  = 1'b1;
      assign rej_v[i]  = 1'b0;
      assign used_v[i] = 1'b1;
      assign link_v[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rmp_capture.sv
module rmp_capture
  import rmp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNTW = WOFF_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic                         sof,
  input  logic [31:0]                  data,
  input  logic [DEPTH-1:0][31:0]       key_v,
  input  logic [DEPTH-1:0][31:0]       mask_v,
  input  logic [DEPTH-1:0][WOFF_W-1:0] woff_v,
  output logic [DEPTH-1:0]             hit
);
  logic [CNTW-1:0]  cnt;
  logic [CNTW-1:0]  cur;
  logic [DEPTH-1:0] now;

  assign cur = sof ? '0 : cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign now[i] = (cur == {1'b0, woff_v[i]}) &&
                    (((data ^ key_v[i]) & mask_v[i]) == 32'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= '0;
    end else if (take) begin
      cnt <= (&cur) ? cur : cur + 1'b1;
      hit <= (sof ? '0 : hit) | now;
    end
  end
endmodule

// File: rtl/rmp_pick.sv
module rmp_pick #(
  parameter int DEPTH = 64
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [DEPTH-1:0] used,
  input  logic [DEPTH-1:0] link,
  input  logic [DEPTH-1:0] acc,
  input  logic [DEPTH-1:0] rej,
  output logic             drop
);
  logic [DEPTH-1:0] frag;
  logic [DEPTH-1:0] rule;
  logic [DEPTH-1:0] dec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rule
    if (i == 0 || i == DEPTH - 1) begin : g_head
      assign frag[i] = 1'b0;
    end else begin : g_mid
      assign frag[i] = used[i-1] & link[i-1];
    end
    if (i < DEPTH - 1) begin : g_lk
      assign rule[i] = used[i] & ~frag[i] & hit[i] &
                       (~link[i] | (hit[i+1] & used[i+1]));
    end else begin : g_end
      assign rule[i] = used[i] & hit[i];
    end
    assign dec[i] = rule[i] & (acc[i] | rej[i]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    drop  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (dec[i] && !found) begin
        found = 1'b1;
        drop  = rej[i];
      end
    end
  end
endmodule

// File: rtl/rx_match_parser.sv
module rx_match_parser
  import rmp_pkg::*;
#(
  parameter int DEPTH         = 64,   // 64, 128 or 256
  parameter int MAX_OFF_BYTES = 64,   // 64, 128 or 256
  localparam int IDXW         = $clog2(DEPTH),
  localparam int MAX_WOFF     = MAX_OFF_BYTES / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [31:0]       cfg_key,
  input  logic [31:0]       cfg_mask,
  input  logic [WOFF_W-1:0] cfg_woff,
  input  logic              cfg_acc,
  input  logic              cfg_rej,
  input  logic              cfg_used,
  input  logic              cfg_link,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              vd_valid,
  output logic              vd_drop
);
  logic [DEPTH-1:0][31:0]       key_v, mask_v;
  logic [DEPTH-1:0][WOFF_W-1:0] woff_v;
  logic [DEPTH-1:0]             acc_v, rej_v, used_v, link_v, hit;
  logic                         take, pending;
  rmp_entry_t                   wr;

  assign wr = '{key: cfg_key, mask: cfg_mask, woff: cfg_woff, acc: cfg_acc,
                rej: cfg_rej, used: cfg_used, link: cfg_link};

  assign in_ready = ~pending;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= take & in_eof;
  end

  rmp_table #(.DEPTH(DEPTH), .MAX_WOFF(MAX_WOFF)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wr(wr),
    .key_v(key_v), .mask_v(mask_v), .woff_v(woff_v), .acc_v(acc_v),
    .rej_v(rej_v), .used_v(used_v), .link_v(link_v)
  );

  rmp_capture #(.DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .data(in_data),
    .key_v(key_v), .mask_v(mask_v), .woff_v(woff_v), .hit(hit)
  );

  rmp_pick #(.DEPTH(DEPTH)) u_pick (
    .hit(hit), .used(used_v), .link(link_v), .acc(acc_v), .rej(rej_v),
    .drop(vd_drop)
  );

  assign vd_valid = pending;
endmodule

// File: rtl/rmp_checker.sv
module rmp_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_eof,
  input logic vd_valid,
  input logic vd_drop
);
  p_verdict_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eof) |=> vd_valid);

  p_no_verdict_mid_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_eof) |=> !vd_valid);

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> (!vd_valid && in_ready));

  p_drop_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |-> !$isunknown(vd_drop));
endmodule

bind rx_match_parser rmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eof(in_eof), .vd_valid(vd_valid), .vd_drop(vd_drop)
);

// File: tb/tb_rx_match_parser.sv
module tb_rx_match_parser;
  localparam int DEPTH = 64;
  localparam int NV    = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, cfg_acc = 0, cfg_rej = 0, cfg_used = 0, cfg_link = 0;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_key = '0, cfg_mask = '0;
  logic [7:0]  cfg_woff = '0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [31:0] in_data = '0;
  logic        in_ready, vd_valid, vd_drop;
  int          total = 0, bad = 0;
  logic [31:0] fbuf [0:31];

  always #5 clk = ~clk;

  rx_match_parser #(.DEPTH(DEPTH), .MAX_OFF_BYTES(64)) dut (.*);

  // {w0, w1, w2, w3, w4, expected drop}
  localparam logic [160:0] VEC [NV] = '{
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0},
    {32'h0, 32'hAAAA5555, 32'h0, 32'h0, 32'h0, 1'b1},
    {32'h0, 32'h0, 32'h12345678, 32'h0, 32'h0, 1'b0},
    {32'h0, 32'hAAAA0000, 32'h12345678, 32'h0, 32'h0, 1'b1},
    {32'h0, 32'h0, 32'h12349999, 32'h0, 32'h0, 1'b1},
    {32'h0, 32'h0, 32'h0, 32'hCCDDEE42, 32'h000000BB, 1'b1},
    {32'h0, 32'h0, 32'h0, 32'hCCDDEE42, 32'h0, 1'b0},
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h990000BB, 1'b0},
    {32'hDEADBEEF, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1},
    {32'hDEAD0001, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1}
  };
  localparam string VTAG [NV] = '{
    "R6 no rule", "R2 masked half", "R3 accept before later reject",
    "R3 reject before later accept", "R3 later reject", "R5 pair hit",
    "R5 first half only", "R5 second half alone", "R4 unused skip and R3 no-action",
    "R3 both flags"
  };

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] key, input logic [31:0] mask,
                    input int woff, input logic acc, input logic rej,
                    input logic used, input logic link);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_key = key; cfg_mask = mask;
    cfg_woff = 8'(woff); cfg_acc = acc; cfg_rej = rej; cfg_used = used; cfg_link = link;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_buf();
    for (int k = 0; k < 32; k++) fbuf[k] = '0;
  endtask

  task automatic send(input int n, input int gap, input logic exp, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0 && gap > 0) begin
        in_valid = 0;
        repeat (gap) @(negedge clk);
      end
      if (k == 0) chk(in_ready, 1'b1, {tag, " R10 ready before frame"});
      in_valid = 1; in_data = fbuf[k]; in_sof = (k == 0); in_eof = (k == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    chk(vd_valid, 1'b1, {tag, " R9 strobe"});
    chk(in_ready, 1'b0, {tag, " R10 ready low in verdict cycle"});
    chk(vd_drop, exp, {tag, " verdict"});
    @(negedge clk);
    chk(vd_valid, 1'b0, {tag, " R9 single pulse"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(vd_valid, 1'b0, "R11 no verdict after reset");
    chk(in_ready, 1'b1, "R11 ready after reset");
    clear_buf();
    send(1, 0, 1'b0, "R11 R6 catch-all from reset");

    // rule set
    wr(0, 32'hAAAA0000, 32'hFFFF0000, 1, 0, 1, 1, 0);
    wr(1, 32'h12345678, 32'hFFFFFFFF, 2, 1, 0, 1, 0);
    wr(2, 32'hCCDDEE00, 32'hFFFFFF00, 3, 0, 1, 1, 1);   // R5 first half, linked
    wr(3, 32'h000000BB, 32'h000000FF, 4, 0, 1, 1, 0);   // R5 second half
    wr(4, 32'hDEADBEEF, 32'hFFFFFFFF, 0, 1, 0, 0, 0);   // R4 unused accept
    wr(5, 32'hDEADBEEF, 32'hFFFFFFFF, 0, 0, 0, 1, 0);   // R3 no action
    wr(6, 32'hDEAD0000, 32'hFFFF0000, 0, 1, 1, 1, 0);   // R3 both flags
    wr(7, 32'h00000077, 32'h000000FF, 16, 0, 1, 1, 0);  // R7 limit offset
    wr(8, 32'h12340000, 32'hFFFF0000, 2, 0, 1, 1, 0);

    for (int v = 0; v < NV; v++) begin
      clear_buf();
      for (int w = 0; w < 5; w++) fbuf[w] = VEC[v][160 - 32*w -: 32];
      send(5, 0, VEC[v][0], VTAG[v]);
    end

    clear_buf(); fbuf[16] = 32'h00000077;
    send(17, 0, 1'b1, "R7 offset at limit hits");
    clear_buf();
    send(16, 0, 1'b0, "R8 short frame misses");

    wr(9, 32'h0, 32'h0, 17, 0, 1, 1, 0);
    clear_buf();
    send(18, 0, 1'b0, "R7 over-limit write ignored");

    wr(63, 32'h0, 32'h0, 0, 0, 1, 1, 0);
    clear_buf();
    send(2, 0, 1'b0, "R6 catch-all write ignored");

    clear_buf(); fbuf[3] = 32'hCCDDEE42; fbuf[4] = 32'h000000BB;
    send(5, 2, 1'b1, "R10 R2 idle cycles in frame");

    wr(0, 32'hAAAA0000, 32'hFFFF0000, 1, 0, 1, 0, 0);
    clear_buf(); fbuf[1] = 32'hAAAA5555;
    send(3, 0, 1'b0, "R1 rewrite removes rule");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule